// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block is a small periodic timer. It raises an interrupt while the system runs and a wake request while the system sleeps. It counts ticks from one of two sources. One is an always-on low-frequency tick of about 1 kHz. The other is a high-frequency tick that stops existing in stop modes. A 3-bit period code picks a power-of-two interval of 2 to 128 ticks. Code zero parks the timer.

Software sees one 8-bit control/status register, which the block decodes as follows:

- Bits [2:0] hold the period code.
- Bit 4 is the source select: 0 selects the low-frequency tick, 1 selects the high-frequency tick.
- Bit 5 is the interrupt enable.
- Bit 6 is a write-only acknowledge.
- Bit 7 is the read-only expiry flag.
- Bit 3 is reserved and reads 0.

The tick inputs are single-cycle pulses already synchronised to `clk`. `hf_alive` low means the high-frequency source is absent. `in_stop` high means the system is in a stop mode. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `wake_tick_timer`

## Requirements
- R1: After reset the register reads 0x00 and `irq` and `wake` are low.
- R2: With period code n (1..7), the flag (bit 7) sets at the clock edge of the 2^n-th selected tick counted from zero. The count then wraps to zero and continues.
- R3: With period code 0 the count is held at zero and the flag never sets.
- R4: Source bit 4 = 0 counts `lf_tick`. Source bit 4 = 1 counts `hf_tick`. The unselected tick has no effect.
- R5: With the high-frequency source selected, `hf_tick` pulses are ignored while `hf_alive` is low. Counting resumes from the held value when `hf_alive` returns high.
- R6: With the low-frequency source selected, counting and expiry continue unchanged while `in_stop` is high.
- R7: Writing 1 to bit 6 clears the flag. Bit 6 and bit 3 always read 0. Writing bit 7 has no effect on the flag.
- R8: If an acknowledge write and an expiry happen in the same cycle, the flag is set afterwards.
- R9: A write whose period code or source bit differs from the current value restarts the count from zero, and no expiry occurs in that cycle. A write that keeps both fields does not disturb the count.
- R10: `irq` equals the flag ANDed with the interrupt enable (bit 5).
- R11: `wake` is a one-cycle pulse, high in the cycle after an expiry edge that occurred while `in_stop` was high. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | Low-frequency tick pulse, always running |
| hf_tick | input | 1 | High-frequency tick pulse |
| hf_alive | input | 1 | High when the high-frequency source is running |
| in_stop | input | 1 | High while the system is in a stop mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request pulse |

## Verification
The main function is tried with several tick patterns.

- A tick on every cycle measures the exact period length.
- Sparse high-frequency ticks with the source toggled off separate a halted count from a restarted one.
- Stop-mode runs on the low-frequency source show that the count survives and that the wake pulse lines up with the flag edge.
- Back-to-back acknowledge writes against a 2-tick period force an acknowledge onto an expiry edge.
- Rewrites that keep or change the period code separate a restart from an untouched count.

// File: rtl/wtt_pkg.sv
package wtt_pkg;
  localparam int REG_W   = 8;
  localparam int F_SRC   = 4;
  localparam int F_IE    = 5;
  localparam int F_ACK   = 6;
  localparam int F_FLAG  = 7;

  typedef enum logic {
    SRC_LF = 1'b0,
    SRC_HF = 1'b1
  } src_e;
endpackage

// File: rtl/wtt_tick_sel.sv
module wtt_tick_sel
  import wtt_pkg::*;
(
  input  logic lf_tick,
  input  logic hf_tick,
  input  logic hf_alive,
  input  src_e src,
  output logic tick
);
  // high-frequency pulses only count while that source is present
  logic hf_gated;
  assign hf_gated = hf_tick & hf_alive;

  always_comb begin
    unique case (src)
      SRC_HF:  tick = hf_gated;
      default: tick = lf_tick;
    endcase
  end
endmodule

// File: rtl/wtt_period_cnt.sv
module wtt_period_cnt #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W:0]   limit;
  logic             active;
  logic             at_last;

  assign limit   = ({{CNT_W{1'b0}}, 1'b1} << sel) - 1'b1;
  assign active  = (sel != '0);
  assign at_last = (cnt_q == limit[CNT_W-1:0]);
  assign expire  = tick & active & ~restart & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !active) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wtt_status.sv
module wtt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  input  logic in_stop,
  input  logic ie,
  output logic flag_q,
  output logic wake_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      // a fresh expiry outranks a simultaneous acknowledge
      flag_q <= expire | (flag_q & ~ack);
      wake_q <= expire & in_stop;
    end
  end

  assign irq = flag_q & ie;
endmodule

// File: rtl/wake_tick_timer.sv
module wake_tick_timer
  import wtt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_tick,
  input  logic             hf_tick,
  input  logic             hf_alive,
  input  logic             in_stop,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             irq,
  output logic             wake
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  src_e             src_q;
  logic             ie_q;
  logic [SEL_W-1:0] sel_w;
  src_e             src_w;
  logic             restart;
  logic             ack;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             flag_q;
  logic             unused_bits;

  assign sel_w       = cfg_wdata[SEL_W-1:0];
  assign src_w       = src_e'(cfg_wdata[F_SRC]);
  assign restart     = cfg_we & ((sel_w != sel_q) | (src_w != src_q));
  assign ack         = cfg_we & cfg_wdata[F_ACK];
  assign unused_bits = ^{cfg_wdata[F_FLAG], cfg_wdata[F_SRC-1:SEL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      src_q <= SRC_LF;
      ie_q  <= 1'b0;
    end else if (cfg_we) begin
      sel_q <= sel_w;
      src_q <= src_w;
      ie_q  <= cfg_wdata[F_IE];
    end
  end

  wtt_tick_sel u_tsel (
    .lf_tick  (lf_tick),
    .hf_tick  (hf_tick),
    .hf_alive (hf_alive),
    .src      (src_q),
    .tick     (tick)
  );

  wtt_period_cnt #(.SEL_W(SEL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel_q),
    .tick    (tick),
    .restart (restart),
    .cnt_q   (cnt_q),
    .expire  (expire)
  );

  wtt_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .ack     (ack),
    .in_stop (in_stop),
    .ie      (ie_q),
    .flag_q  (flag_q),
    .wake_q  (wake),
    .irq     (irq)
  );

  always_comb begin
    cfg_rdata                 = '0;
    cfg_rdata[SEL_W-1:0]      = sel_q;
    cfg_rdata[F_SRC]          = src_q;
    cfg_rdata[F_IE]           = ie_q;
    cfg_rdata[F_FLAG]         = flag_q;
  end
endmodule

// File: rtl/wake_tick_timer_chk.sv
module wake_tick_timer_chk #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hf_alive,
  input logic             cfg_we,
  input logic [7:0]       cfg_rdata,
  input logic             irq,
  input logic             wake,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_q
);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (cfg_rdata[7] & cfg_rdata[5]));

  // R11
  wake_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> cfg_rdata[7]);

  // R7
  wo_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[6] == 1'b0) && (cfg_rdata[3] == 1'b0));

  // R3
  parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[SEL_W-1:0] == '0 && !cfg_rdata[7]) |=> !cfg_rdata[7]);

  // R5
  hf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4] && !hf_alive && !cfg_we) |=> $stable(cnt_q));

  // R8
  expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cfg_rdata[7]);
endmodule

bind wake_tick_timer wake_tick_timer_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hf_alive  (hf_alive),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .irq       (irq),
  .wake      (wake),
  .expire    (expire),
  .cnt_q     (cnt_q)
);

// File: tb/sim_wake_tick_timer.sv
`timescale 1ns/1ps
module sim_wake_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lf_tick = 1'b0, hf_tick = 1'b0, hf_alive = 1'b1, in_stop = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       irq, wake;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wake_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .hf_tick(hf_tick),
    .hf_alive(hf_alive), .in_stop(in_stop), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .wake(wake)
  );

  // behavioural reference state
  int m_sel = 0, m_cnt = 0;
  bit m_src = 0, m_ie = 0, m_flag = 0, m_wake = 0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit tk, rs, ex;
    if (!rst_n) begin
      m_sel = 0; m_cnt = 0; m_src = 0; m_ie = 0; m_flag = 0; m_wake = 0;
    end else begin
      tk = m_src ? (hf_tick && hf_alive) : lf_tick;
      rs = cfg_we && ((int'(cfg_wdata[2:0]) != m_sel) || (cfg_wdata[4] != m_src));
      ex = 0;
      if (rs || m_sel == 0) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == (1 << m_sel) - 1) begin m_cnt = 0; ex = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_wake = ex && in_stop;
      m_flag = ex || (m_flag && !(cfg_we && cfg_wdata[6]));
      if (cfg_we) begin
        m_sel = int'(cfg_wdata[2:0]); m_src = cfg_wdata[4]; m_ie = cfg_wdata[5];
      end
    end
    #3;
    check({cur_req, " rdata"}, int'(cfg_rdata),
          (int'(m_flag) << 7) | (int'(m_ie) << 5) | (int'(m_src) << 4) | m_sel);
    check({cur_req, " irq"}, int'(irq), int'(m_flag && m_ie));
    check({cur_req, " wake"}, int'(wake), int'(m_wake));
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int k;
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    // R2: period 2 on every-cycle low-frequency ticks
    cur_req = "R2"; wr(8'h21); lf_tick = 1'b1; idle(9);
    // R2: measured period for code 3 is 8 ticks
    lf_tick = 1'b0; wr(8'h63); lf_tick = 1'b1; k = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #3; k++;
      if (cfg_rdata[7]) break;
    end
    check("R2 period", k, 8);
    // R10: enable off hides irq while flag stays
    cur_req = "R10"; lf_tick = 1'b0; wr(8'h03); idle(2);
    check("R10 irq off", int'(irq), 0);
    check("R10 flag kept", int'(cfg_rdata[7]), 1);
    wr(8'h23); idle(2);
    // R7: acknowledge clears, flag bit write ignored
    cur_req = "R7"; wr(8'h63); idle(2);
    check("R7 cleared", int'(cfg_rdata[7]), 0);
    wr(8'hA3); idle(2);
    check("R7 flag write ignored", int'(cfg_rdata[7]), 0);
    // R3: code zero parks the timer
    cur_req = "R3"; wr(8'h20); lf_tick = 1'b1; idle(20);
    check("R3 no flag", int'(cfg_rdata[7]), 0);
    // R4 / R5: high-frequency source, sparse ticks, then source lost
    cur_req = "R4"; lf_tick = 1'b1; wr(8'h32);
    for (int i = 0; i < 12; i++) begin
      hf_tick = (i % 2 == 0); @(negedge clk);
    end
    wr(8'h72); cur_req = "R5"; hf_alive = 1'b0;
    for (int i = 0; i < 3; i++) begin
      hf_tick = 1'b1; @(negedge clk); hf_tick = 1'b0; @(negedge clk);
    end
    check("R5 halted", int'(cfg_rdata[7]), 0);
    hf_alive = 1'b1;
    for (int i = 0; i < 10; i++) begin
      hf_tick = (i % 3 == 0); @(negedge clk);
    end
    hf_tick = 1'b0;
    // R6 / R11: stop mode on the low-frequency source
    cur_req = "R6"; in_stop = 1'b1; lf_tick = 1'b1; wr(8'h67);
    idle(135);
    check("R6 flag in stop", int'(cfg_rdata[7]), 1);
    cur_req = "R11"; wr(8'h62); idle(12);
    in_stop = 1'b0; idle(6);
    // R8: acknowledge on every cycle against a 2-tick period
    cur_req = "R8"; wr(8'h61);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h61;
    idle(8); cfg_we = 1'b0; idle(2);
    // R9: rewrite with same fields keeps count, changed field restarts
    cur_req = "R9"; lf_tick = 1'b0; wr(8'h63); lf_tick = 1'b1; idle(5);
    lf_tick = 1'b0; wr(8'h23); lf_tick = 1'b1; idle(3);
    lf_tick = 1'b0; idle(1);
    check("R9 kept count", int'(cfg_rdata[7]), 1);
    wr(8'h63); lf_tick = 1'b1; idle(4);
    lf_tick = 1'b0; wr(8'h24); lf_tick = 1'b1; idle(12);
    lf_tick = 1'b0; idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule